// File: doc/BRIEF.md
# Power-Gated I2C Control Register Slave

This block is an I2C slave for a regulator device. It watches the open-drain SCL and SDA lines through two-flop synchronizers and detects START and STOP conditions. It shifts bytes in most significant bit first and pulls SDA low as its acknowledge. A small bank of 8-bit control registers is written over the bus and driven out on `ctrl_o`. A read returns the stored control bits together with live status bits.

The first byte after START is the address byte. Its upper six bits must equal a parameterised prefix (default `000100`). Bit 1 is don't-care, and bit 0 selects read (1) or write (0). While the power-good input from the undervoltage monitor is low, the slave acknowledges nothing and stores nothing. The bus master sees every byte go unanswered.

Data bytes in one transfer fill the registers in order, starting at register 0 and wrapping at the end of the bank. Reads walk the registers in the same way. In register 0 a mask marks some bits as status bits. Writes leave those bits unchanged, and reads show the `status_i` value in those positions.

Top module: `pgi2c_regslave`

## Requirements
- R1: After START, an address byte whose bits [7:2] equal `000100` is acknowledged whatever bit 1 holds (0x10, 0x11, 0x12 and 0x13 all match). Bit 0 = 1 selects read and bit 0 = 0 selects write.
- R2: An address byte that does not match gets no acknowledge. SDA stays released and every later byte is ignored until the next START, so `ctrl_o` is unchanged.
- R3: While `pwr_good_i` is low, SDA is never pulled low in any acknowledge slot. A data byte received while it is low is not stored and ends the transfer for the slave.
- R4: Write data bytes are received MSB first and acknowledged. They are stored in register 0, 1, ... and the index wraps to 0 after the last register. `ctrl_o[8*k+7:8*k]` is register k, and the index restarts at 0 on every START.
- R5: Bits set in the read-only mask (default 0x03) of register 0 are never changed by writes and read back as zero on `ctrl_o`. In a read, those bit positions carry `status_i`.
- R6: In a read, the slave drives register contents MSB first on SDA, starting at register 0. After each master acknowledge it continues with the next register, wrapping at the end of the bank. After a master NACK it releases SDA.
- R7: After reset, all register bits are 0 and SDA is released.
- R8: A START in the middle of a byte drops the partial byte and restarts address reception.
- R9: A STOP in the middle of a byte drops the partial byte, releases SDA and leaves the registers unchanged. The next START is handled normally.
- R10: The SDA drive changes only after a falling SCL edge (or on START or STOP), never while SCL stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| pwr_good_i | input | 1 | Power-good from undervoltage monitor; low blocks acknowledge and storage |
| status_i | input | 8 | Live status bits shown in read-only positions of register 0 |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| ctrl_o | output | 16 | Control register contents, register k at bits [8k+7:8k] |

## Verification
The assertions check on every cycle that the acknowledge drive stays off while power-good is low. They also check that SDA is released when the slave is idle or receiving an address, and that START and STOP force the expected state. Finally, they check that the SDA drive moves only after SCL falls, and that the registers change only on a powered SCL rising edge. Which address patterns match, the wrapping of the register index, the masking of status bits and the dropping of partial bytes on START or STOP can be seen only in the bench's scenarios. There, bus transfers are played out and the acknowledge bits, read bytes and register outputs are compared with a behavioural model.

// File: rtl/pgi2c_pkg.sv
package pgi2c_pkg;

    localparam int SYNC_STAGES = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WBYTE,
        ST_WACK,
        ST_RBYTE,
        ST_RACK
    } st_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [7:0] b, input logic [5:0] pfx);
        return b[7:2] == pfx;
    endfunction

endpackage

// File: rtl/pgi2c_line_sync.sv
module pgi2c_line_sync #(
    parameter int   STAGES  = pgi2c_pkg::SYNC_STAGES,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pgi2c_bus_events.sv
module pgi2c_bus_events
    import pgi2c_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
        ev.sda      = sda_s;
    end
endmodule

// File: rtl/pgi2c_reg_bank.sv
module pgi2c_reg_bank #(
    parameter int         NREG    = 2,
    parameter logic [7:0] RO_MASK = 8'h03,
    localparam int        IW      = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [IW-1:0]   widx,
    input  logic [7:0]      wdata,
    input  logic [IW-1:0]   ridx,
    input  logic [7:0]      status,
    output logic [7:0]      rdata,
    output logic [NREG*8-1:0] regs_flat
);
    logic [7:0] store [NREG];
    logic [7:0] view  [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [7:0] MSK = (g == 0) ? RO_MASK : 8'h00;

        always_ff @(posedge clk) begin
            if (rst)                         store[g] <= '0;
            else if (we && widx == IW'(g))   store[g] <= (wdata & ~MSK) | (store[g] & MSK);
        end

        assign view[g] = (store[g] & ~MSK) | (status & MSK);
        assign regs_flat[g*8 +: 8] = store[g];
    end

    assign rdata = view[ridx];
endmodule

// File: rtl/pgi2c_regslave.sv
module pgi2c_regslave
    import pgi2c_pkg::*;
#(
    parameter int         NREG     = 2,
    parameter logic [7:0] RO_MASK  = 8'h03,
    parameter logic [5:0] ADDR_PFX = 6'b000100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              pwr_good_i,
    input  logic [7:0]        status_i,
    output logic              sda_oe_o,
    output logic [NREG*8-1:0] ctrl_o
);
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

    logic    scl_s, sda_s;
    bus_ev_t ev;
    logic    start_w, stop_w, rise_w, fall_w;

    st_e           st_q;
    logic [2:0]    cnt_q;
    logic [6:0]    sh_q;
    logic          rw_q, seen9_q, mack_q, drv_q;
    logic [IW-1:0] idx_q;
    logic [7:0]    byte_in, rd_byte;
    logic          wr_en, ack_slot;

    function automatic logic [IW-1:0] nxt_idx(input logic [IW-1:0] i);
        return (i == IW'(NREG - 1)) ? '0 : i + 1'b1;
    endfunction

    pgi2c_line_sync u_scl_sync (.clk(clk), .rst(rst), .d(scl_i), .q(scl_s));
    pgi2c_line_sync u_sda_sync (.clk(clk), .rst(rst), .d(sda_i), .q(sda_s));

    pgi2c_bus_events u_events (.clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s), .ev(ev));

    assign start_w = ev.start;
    assign stop_w  = ev.stop;
    assign rise_w  = ev.scl_rise;
    assign fall_w  = ev.scl_fall;

    assign byte_in = {sh_q, ev.sda};
    assign wr_en   = (st_q == ST_WBYTE) && ev.scl_rise && (cnt_q == 3'd7)
                     && pwr_good_i && !ev.start && !ev.stop;

    pgi2c_reg_bank #(.NREG(NREG), .RO_MASK(RO_MASK)) u_bank (
        .clk(clk), .rst(rst), .we(wr_en), .widx(idx_q), .wdata(byte_in),
        .ridx(idx_q), .status(status_i), .rdata(rd_byte), .regs_flat(ctrl_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            rw_q    <= 1'b0;
            seen9_q <= 1'b0;
            mack_q  <= 1'b0;
            drv_q   <= 1'b0;
            idx_q   <= '0;
        end else if (ev.start) begin
            st_q    <= ST_ADDR;
            cnt_q   <= '0;
            idx_q   <= '0;
            drv_q   <= 1'b0;
            seen9_q <= 1'b0;
        end else if (ev.stop) begin
            st_q  <= ST_IDLE;
            drv_q <= 1'b0;
        end else begin
            case (st_q)
                ST_ADDR: if (ev.scl_rise) begin
                    sh_q  <= byte_in[6:0];
                    cnt_q <= cnt_q + 3'd1;
                    if (cnt_q == 3'd7) begin
                        if (addr_hit(byte_in, ADDR_PFX) && pwr_good_i) begin
                            rw_q    <= byte_in[0];
                            st_q    <= ST_AACK;
                            seen9_q <= 1'b0;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                end
                ST_AACK, ST_WACK: begin
                    if (ev.scl_rise) seen9_q <= 1'b1;
                    if (ev.scl_fall) begin
                        if (!seen9_q) begin
                            drv_q <= 1'b1;
                        end else begin
                            cnt_q <= '0;
                            if (st_q == ST_AACK && rw_q) begin
                                st_q  <= ST_RBYTE;
                                sh_q  <= rd_byte[6:0];
                                drv_q <= ~rd_byte[7];
                            end else begin
                                st_q  <= ST_WBYTE;
                                drv_q <= 1'b0;
                            end
                        end
                    end
                end
                ST_WBYTE: if (ev.scl_rise) begin
                    sh_q  <= byte_in[6:0];
                    cnt_q <= cnt_q + 3'd1;
                    if (cnt_q == 3'd7) begin
                        if (pwr_good_i) begin
                            idx_q   <= nxt_idx(idx_q);
                            st_q    <= ST_WACK;
                            seen9_q <= 1'b0;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                end
                ST_RBYTE: if (ev.scl_fall) begin
                    if (cnt_q == 3'd7) begin
                        drv_q   <= 1'b0;
                        st_q    <= ST_RACK;
                        seen9_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + 3'd1;
                        drv_q <= ~sh_q[6];
                        sh_q  <= {sh_q[5:0], 1'b0};
                    end
                end
                ST_RACK: begin
                    if (ev.scl_rise) begin
                        seen9_q <= 1'b1;
                        mack_q  <= ~ev.sda;
                        if (!ev.sda) idx_q <= nxt_idx(idx_q);
                    end
                    if (ev.scl_fall && seen9_q) begin
                        if (mack_q) begin
                            st_q  <= ST_RBYTE;
                            cnt_q <= '0;
                            sh_q  <= rd_byte[6:0];
                            drv_q <= ~rd_byte[7];
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign ack_slot = (st_q == ST_AACK) || (st_q == ST_WACK);
    assign sda_oe_o = drv_q & (~ack_slot | pwr_good_i);

endmodule

// File: rtl/pgi2c_regslave_chk.sv
module pgi2c_regslave_chk
    import pgi2c_pkg::*;
#(
    parameter int NREG = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_good_i,
    input logic              sda_oe_o,
    input logic [NREG*8-1:0] ctrl_o,
    input st_e               st,
    input logic              drv,
    input logic              start_w,
    input logic              stop_w,
    input logic              rise_w,
    input logic              fall_w
);
    p_unpowered_no_ack_r3: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_AACK || st == ST_WACK) && !pwr_good_i) |-> !sda_oe_o);

    p_idle_released_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE || st == ST_ADDR) |-> !sda_oe_o);

    p_start_restarts_r8: assert property (@(posedge clk) disable iff (rst)
        start_w |=> (st == ST_ADDR && !drv));

    p_stop_idles_r9: assert property (@(posedge clk) disable iff (rst)
        (stop_w && !start_w) |=> (st == ST_IDLE && !drv));

    p_drive_after_fall_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(drv) |-> $past(fall_w || start_w || stop_w));

    p_store_on_rise_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_o) |-> $past(rise_w && pwr_good_i));

    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (ctrl_o == '0 && !drv));
endmodule

bind pgi2c_regslave pgi2c_regslave_chk #(.NREG(NREG)) chk_i (
    .clk(clk), .rst(rst), .pwr_good_i(pwr_good_i), .sda_oe_o(sda_oe_o),
    .ctrl_o(ctrl_o), .st(st_q), .drv(drv_q), .start_w(start_w),
    .stop_w(stop_w), .rise_w(rise_w), .fall_w(fall_w)
);

// File: tb/pgi2c_regslave_tb_top.sv
module pgi2c_regslave_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        pg = 1'b1;
    logic [7:0]  status = 8'h00;
    logic        oe;
    logic [15:0] ctrl;
    logic        sda_line;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    logic quiet = 1'b0;
    logic done  = 1'b0;

    logic [7:0] exp_r0 = 8'h00;
    logic [7:0] exp_r1 = 8'h00;
    int         m_idx  = 0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~oe;

    pgi2c_regslave dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .pwr_good_i(pg), .status_i(status), .sda_oe_o(oe), .ctrl_o(ctrl)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    // model of register storage: writes masked, index wraps over two registers
    task automatic m_store(input logic [7:0] b);
        if (m_idx == 0) exp_r0 = b & 8'hFC;
        else            exp_r1 = b;
        m_idx = (m_idx + 1) % 2;
    endtask

    function automatic logic [7:0] m_read(input int i);
        return (i == 0) ? ((exp_r0 & 8'hFC) | (status & 8'h03)) : exp_r1;
    endfunction

    task automatic bit_io(input logic b, output logic seen);
        wt(4); sda_m = b;
        wt(4); scl_m = 1'b1;
        wt(4); seen = sda_line;
        wt(4); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, s);
            b[i] = s;
        end
        bit_io(~mack, s);
    endtask

    task automatic bus_start();
        wt(4); sda_m = 1'b1;
        wt(4); scl_m = 1'b1;
        wt(8); sda_m = 1'b0;
        wt(8); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wt(4); sda_m = 1'b0;
        wt(4); scl_m = 1'b1;
        wt(8); sda_m = 1'b1;
        wt(8);
    endtask

    // per-clock comparison: drive steady while SCL high (R10), released in quiet windows (R2/R3)
    logic scl_prev = 1'b1;
    logic oe_prev  = 1'b0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            cyc++;
            n_cmp++;
            if (scl_prev && scl_m && (oe !== oe_prev)) begin
                n_bad++;
                $display("FAIL R10: sda drive moved to %b while SCL high, expected %b", oe, oe_prev);
            end else if (quiet && oe !== 1'b0) begin
                n_bad++;
                $display("FAIL R2/R3: sda drive actual %b expected 0", oe);
            end
            if (cyc > 150000) begin
                n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
        scl_prev = scl_m;
        oe_prev  = oe;
    end

    initial begin
        logic       a;
        logic [7:0] rb;
        wt(5);
        rst = 1'b0;
        wt(4);
        chk("R7 ctrl", {16'h0, ctrl}, 32'h0);
        chk("R7 sda", {31'h0, oe}, 32'h0);

        // write one byte, RO bits masked
        bus_start();
        send_byte(8'h10, a); chk("R1 addr 0x10", {31'h0, a}, 32'h1);
        m_idx = 0;
        send_byte(8'hA5, a); chk("R4 data ack", {31'h0, a}, 32'h1); m_store(8'hA5);
        bus_stop();
        chk("R5 ctrl masked", {16'h0, ctrl}, {16'h0, exp_r1, exp_r0});

        // three bytes, index wraps
        bus_start();
        send_byte(8'h12, a); chk("R1 addr 0x12", {31'h0, a}, 32'h1);
        m_idx = 0;
        send_byte(8'h3C, a); chk("R4 byte0", {31'h0, a}, 32'h1); m_store(8'h3C);
        send_byte(8'h81, a); chk("R4 byte1", {31'h0, a}, 32'h1); m_store(8'h81);
        send_byte(8'hFF, a); chk("R4 byte2", {31'h0, a}, 32'h1); m_store(8'hFF);
        bus_stop();
        chk("R4 wrap ctrl", {16'h0, ctrl}, {16'h0, exp_r1, exp_r0});

        // mismatching addresses
        bus_start();
        quiet = 1'b1;
        send_byte(8'h20, a); chk("R2 nomatch 0x20", {31'h0, a}, 32'h0);
        send_byte(8'h55, a); chk("R2 ignored byte", {31'h0, a}, 32'h0);
        quiet = 1'b0;
        bus_stop();
        bus_start();
        quiet = 1'b1;
        send_byte(8'h14, a); chk("R2 nomatch 0x14", {31'h0, a}, 32'h0);
        quiet = 1'b0;
        bus_stop();
        chk("R2 ctrl kept", {16'h0, ctrl}, {16'h0, exp_r1, exp_r0});

        // power-good low
        pg = 1'b0;
        quiet = 1'b1;
        bus_start();
        send_byte(8'h10, a); chk("R3 addr unpowered", {31'h0, a}, 32'h0);
        send_byte(8'h00, a); chk("R3 data unpowered", {31'h0, a}, 32'h0);
        bus_stop();
        quiet = 1'b0;
        pg = 1'b1;
        bus_start();
        send_byte(8'h10, a); chk("R3 addr powered", {31'h0, a}, 32'h1);
        pg = 1'b0;
        quiet = 1'b1;
        send_byte(8'h00, a); chk("R3 data after drop", {31'h0, a}, 32'h0);
        bus_stop();
        quiet = 1'b0;
        pg = 1'b1;
        chk("R3 ctrl kept", {16'h0, ctrl}, {16'h0, exp_r1, exp_r0});

        // reads with wrap and live status
        status = 8'h02;
        bus_start();
        send_byte(8'h11, a); chk("R1 addr 0x11", {31'h0, a}, 32'h1);
        recv_byte(1'b1, rb); chk("R6 read reg0", {24'h0, rb}, {24'h0, m_read(0)});
        status = 8'h01;
        recv_byte(1'b1, rb); chk("R6 read reg1", {24'h0, rb}, {24'h0, m_read(1)});
        recv_byte(1'b0, rb); chk("R5 read wrap status", {24'h0, rb}, {24'h0, m_read(0)});
        quiet = 1'b1;
        wt(6);
        chk("R6 released after nack", {31'h0, oe}, 32'h0);
        bus_stop();
        quiet = 1'b0;
        bus_start();
        send_byte(8'h13, a); chk("R1 addr 0x13", {31'h0, a}, 32'h1);
        recv_byte(1'b0, rb); chk("R6 read 0x13", {24'h0, rb}, {24'h0, m_read(0)});
        bus_stop();

        // repeated START mid-byte
        bus_start();
        send_byte(8'h10, a);
        for (int i = 0; i < 5; i++) bit_io(1'b0, a);
        bus_start();
        send_byte(8'h10, a); chk("R8 addr after restart", {31'h0, a}, 32'h1);
        m_idx = 0;
        send_byte(8'h5A, a); chk("R8 data ack", {31'h0, a}, 32'h1); m_store(8'h5A);
        bus_stop();
        chk("R8 ctrl", {16'h0, ctrl}, {16'h0, exp_r1, exp_r0});

        // STOP mid-byte
        bus_start();
        send_byte(8'h10, a);
        for (int i = 0; i < 3; i++) bit_io(1'b1, a);
        bus_stop();
        chk("R9 ctrl kept", {16'h0, ctrl}, {16'h0, exp_r1, exp_r0});
        chk("R9 released", {31'h0, oe}, 32'h0);
        bus_start();
        send_byte(8'h11, a); chk("R9 next start", {31'h0, a}, 32'h1);
        recv_byte(1'b0, rb); chk("R9 read after stop", {24'h0, rb}, {24'h0, m_read(0)});
        bus_stop();

        wt(10);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule